// File: doc/BRIEF.md
# Bus Master Security Filter

This block sits on the request path of a bus-mastering device, such as a DMA engine, before the system interconnect. No software registers set it up. Side-band wires carry its whole configuration: one wire gives the security level of the master, and one chooses how a refused access completes. An attribution input arrives with every request and says whether the target address is secure. That input comes from an address-attribution unit outside this block, which need not be the unit the CPU uses.

When a non-secure master addresses secure space, the request is refused. It never reaches the interconnect. The filter completes it locally in one of two ways: with an error response, or as a read-as-zero / write-ignored access with an okay response. A refusal also sets a sticky interrupt, which stays high until a clear input is driven. Every other request passes downstream with its fields unchanged and with a non-secure attribute equal to the master's security level. The response for a passed request comes back unchanged.

The filter handles one transaction at a time. Requests and responses both use a valid/ready handshake.

Top module: `msf_bus_filter`

## Requirements
- R1: With `cfg_ns`=0 (secure master), every request is forwarded whatever `attr_sec` says. Address, write flag and write data reach the downstream port unchanged, and `dn_req_ns`=0.
- R2: With `cfg_ns`=1 and `attr_sec`=0, the request is forwarded with `dn_req_ns`=1. While it is forwarded, `up_req_ready` follows `dn_req_ready`.
- R3: With `cfg_ns`=1 and `attr_sec`=1, the request is refused. `dn_req_valid` stays 0, and the request is accepted at once (`up_req_ready`=1) whatever `dn_req_ready` is.
- R4: With `cfg_err_resp`=1, a refused request completes on the cycle after acceptance with `up_rsp_valid`=1, `up_rsp_err`=1 and `up_rsp_rdata`=0.
- R5: With `cfg_err_resp`=0, a refused request completes with `up_rsp_err`=0 and `up_rsp_rdata`=0. A refused write never shows on the downstream request port.
- R6: Acceptance of a refused request sets `irq` from the next cycle on. `irq` stays 1 until a cycle with `irq_clr`=1.
- R7: A cycle with `irq_clr`=1 makes `irq` 0 on the next cycle. This holds even when a refusal is accepted on that same edge, because clear wins over set.
- R8: For a forwarded request, `up_rsp_valid`, `up_rsp_err` and `up_rsp_rdata` equal the downstream response, and `dn_rsp_ready` equals `up_rsp_ready`.
- R9: Only one transaction is outstanding. From acceptance until its response handshake, `up_req_ready`=0 and `dn_req_valid`=0.
- R10: After reset `irq`=0 and `up_rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_ns | input | 1 | 1: master is non-secure, 0: master is secure |
| cfg_err_resp | input | 1 | 1: refused access returns error, 0: read-as-zero / write-ignored |
| irq_clr | input | 1 | Clears the refusal interrupt; has priority over setting |
| attr_sec | input | 1 | Attribution of the current request address, 1 = secure |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Upstream request ready |
| up_req_write | input | 1 | 1 = write, 0 = read |
| up_req_addr | input | AW | Request address |
| up_req_wdata | input | DW | Write data |
| up_rsp_valid | output | 1 | Upstream response valid |
| up_rsp_ready | input | 1 | Upstream response ready |
| up_rsp_err | output | 1 | Response error flag |
| up_rsp_rdata | output | DW | Response read data |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request ready |
| dn_req_write | output | 1 | Forwarded write flag |
| dn_req_addr | output | AW | Forwarded address |
| dn_req_wdata | output | DW | Forwarded write data |
| dn_req_ns | output | 1 | Non-secure attribute of the forwarded request |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_ready | output | 1 | Downstream response ready |
| dn_rsp_err | input | 1 | Downstream response error |
| dn_rsp_rdata | input | DW | Downstream read data |
| irq | output | 1 | Sticky refusal interrupt |

## Verification
The properties assume that `cfg_ns`, `cfg_err_resp` and `attr_sec` stay steady while a request is waiting. They also assume the downstream side raises `dn_rsp_valid` only while a forwarded transaction is open. The bench changes configuration and attribution only on the falling edge that presents a new request. Its downstream model answers only after it has seen the forwarded request accepted. Random master levels, attributions, response modes, clear pulses and downstream stalls are mixed with directed cases: clear on the same edge as a refusal, and a second request offered while the first is still open.

// File: rtl/msf_pkg.sv
package msf_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FWD   = 2'd1,
      ST_LOCAL = 2'd2
   } msf_state_e;
endpackage

// File: rtl/msf_decide.sv
module msf_decide (
   input  logic cfg_ns,
   input  logic attr_sec,
   output logic blocked
);
   // a non-secure master may not reach secure space; secure masters pass
   always_comb blocked = cfg_ns & attr_sec;
endmodule

// File: rtl/msf_irq_flag.sv
module msf_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_ev,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag <= 1'b0;
      else if (clr)    flag <= 1'b0;
      else if (set_ev) flag <= 1'b1;
   end
endmodule

// File: rtl/msf_txn_ctrl.sv
module msf_txn_ctrl
   import msf_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          blocked,
   input  logic          cfg_ns,
   input  logic          cfg_err_resp,
   input  logic          up_req_valid,
   output logic          up_req_ready,
   input  logic          up_req_write,
   input  logic [AW-1:0] up_req_addr,
   input  logic [DW-1:0] up_req_wdata,
   output logic          up_rsp_valid,
   input  logic          up_rsp_ready,
   output logic          up_rsp_err,
   output logic [DW-1:0] up_rsp_rdata,
   output logic          dn_req_valid,
   input  logic          dn_req_ready,
   output logic          dn_req_write,
   output logic [AW-1:0] dn_req_addr,
   output logic [DW-1:0] dn_req_wdata,
   output logic          dn_req_ns,
   input  logic          dn_rsp_valid,
   output logic          dn_rsp_ready,
   input  logic          dn_rsp_err,
   input  logic [DW-1:0] dn_rsp_rdata,
   output logic          reject_ev
);
   msf_state_e state_q, state_d;
   logic       loc_err_q;
   logic       idle, accept;

   always_comb begin
      idle         = (state_q == ST_IDLE);
      dn_req_valid = idle & up_req_valid & ~blocked;
      up_req_ready = idle & (blocked | dn_req_ready);
      accept       = up_req_valid & up_req_ready;
      reject_ev    = accept & blocked;
      dn_req_write = up_req_write;
      dn_req_addr  = up_req_addr;
      dn_req_wdata = up_req_wdata;
      dn_req_ns    = cfg_ns;
   end

   always_comb begin
      up_rsp_valid = (state_q == ST_LOCAL) | ((state_q == ST_FWD) & dn_rsp_valid);
      up_rsp_err   = (state_q == ST_LOCAL) ? loc_err_q : dn_rsp_err;
      up_rsp_rdata = (state_q == ST_LOCAL) ? '0 : dn_rsp_rdata;
      dn_rsp_ready = (state_q == ST_FWD) & up_rsp_ready;
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (accept) state_d = blocked ? ST_LOCAL : ST_FWD;
         ST_FWD:   if (dn_rsp_valid & up_rsp_ready) state_d = ST_IDLE;
         ST_LOCAL: if (up_rsp_ready) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         loc_err_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (reject_ev) loc_err_q <= cfg_err_resp;
      end
   end
endmodule

// File: rtl/msf_bus_filter.sv
module msf_bus_filter #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_ns,
   input  logic          cfg_err_resp,
   input  logic          irq_clr,
   input  logic          attr_sec,
   input  logic          up_req_valid,
   output logic          up_req_ready,
   input  logic          up_req_write,
   input  logic [AW-1:0] up_req_addr,
   input  logic [DW-1:0] up_req_wdata,
   output logic          up_rsp_valid,
   input  logic          up_rsp_ready,
   output logic          up_rsp_err,
   output logic [DW-1:0] up_rsp_rdata,
   output logic          dn_req_valid,
   input  logic          dn_req_ready,
   output logic          dn_req_write,
   output logic [AW-1:0] dn_req_addr,
   output logic [DW-1:0] dn_req_wdata,
   output logic          dn_req_ns,
   input  logic          dn_rsp_valid,
   output logic          dn_rsp_ready,
   input  logic          dn_rsp_err,
   input  logic [DW-1:0] dn_rsp_rdata,
   output logic          irq
);
   initial begin : param_chk
      assert (AW >= 1 && AW <= 64) else $fatal(1, "msf_bus_filter: AW out of range");
      assert (DW >= 8 && DW <= 64) else $fatal(1, "msf_bus_filter: DW out of range");
   end

   logic blocked;
   logic reject_ev;

   msf_decide u_decide (
      .cfg_ns   (cfg_ns),
      .attr_sec (attr_sec),
      .blocked  (blocked)
   );

   msf_txn_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .blocked      (blocked),
      .cfg_ns       (cfg_ns),
      .cfg_err_resp (cfg_err_resp),
      .up_req_valid (up_req_valid),
      .up_req_ready (up_req_ready),
      .up_req_write (up_req_write),
      .up_req_addr  (up_req_addr),
      .up_req_wdata (up_req_wdata),
      .up_rsp_valid (up_rsp_valid),
      .up_rsp_ready (up_rsp_ready),
      .up_rsp_err   (up_rsp_err),
      .up_rsp_rdata (up_rsp_rdata),
      .dn_req_valid (dn_req_valid),
      .dn_req_ready (dn_req_ready),
      .dn_req_write (dn_req_write),
      .dn_req_addr  (dn_req_addr),
      .dn_req_wdata (dn_req_wdata),
      .dn_req_ns    (dn_req_ns),
      .dn_rsp_valid (dn_rsp_valid),
      .dn_rsp_ready (dn_rsp_ready),
      .dn_rsp_err   (dn_rsp_err),
      .dn_rsp_rdata (dn_rsp_rdata),
      .reject_ev    (reject_ev)
   );

   msf_irq_flag u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_ev (reject_ev),
      .clr    (irq_clr),
      .flag   (irq)
   );
endmodule

// File: rtl/msf_bus_filter_chk.sv
module msf_bus_filter_chk #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_ns,
   input logic          irq_clr,
   input logic          attr_sec,
   input logic          up_req_valid,
   input logic          up_req_ready,
   input logic          up_rsp_valid,
   input logic          up_rsp_ready,
   input logic          up_rsp_err,
   input logic [DW-1:0] up_rsp_rdata,
   input logic          dn_req_valid,
   input logic          dn_req_ns,
   input logic [AW-1:0] dn_req_addr,
   input logic [AW-1:0] up_req_addr,
   input logic          dn_rsp_valid,
   input logic          dn_rsp_ready,
   input logic          dn_rsp_err,
   input logic [DW-1:0] dn_rsp_rdata,
   input logic          irq
);
   a_r3_refused_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
      (up_req_valid && cfg_ns && attr_sec) |-> !dn_req_valid);

   a_r1_ns_attribute: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req_valid |-> (dn_req_ns == cfg_ns && dn_req_addr == up_req_addr));

   a_r4_local_rsp_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (up_req_valid && up_req_ready && cfg_ns && attr_sec) |=> (up_rsp_valid && up_rsp_rdata == '0));

   a_r6_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
      (up_req_valid && up_req_ready && cfg_ns && attr_sec && !irq_clr) |=> irq);

   a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);

   a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr |=> !irq);

   a_r8_rsp_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_rsp_valid && dn_rsp_ready) |->
         (up_rsp_valid && up_rsp_err == dn_rsp_err && up_rsp_rdata == dn_rsp_rdata));

   a_r9_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      up_rsp_valid |-> (!up_req_ready && !dn_req_valid));

   a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (up_req_valid && up_req_ready) |=> !up_req_ready);

   logic unused_ok;
   assign unused_ok = up_rsp_ready;
endmodule

bind msf_bus_filter msf_bus_filter_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_ns       (cfg_ns),
   .irq_clr      (irq_clr),
   .attr_sec     (attr_sec),
   .up_req_valid (up_req_valid),
   .up_req_ready (up_req_ready),
   .up_rsp_valid (up_rsp_valid),
   .up_rsp_ready (up_rsp_ready),
   .up_rsp_err   (up_rsp_err),
   .up_rsp_rdata (up_rsp_rdata),
   .dn_req_valid (dn_req_valid),
   .dn_req_ns    (dn_req_ns),
   .dn_req_addr  (dn_req_addr),
   .up_req_addr  (up_req_addr),
   .dn_rsp_valid (dn_rsp_valid),
   .dn_rsp_ready (dn_rsp_ready),
   .dn_rsp_err   (dn_rsp_err),
   .dn_rsp_rdata (dn_rsp_rdata),
   .irq          (irq)
);

// File: tb/tb_msf_bus_filter.sv
module tb_msf_bus_filter;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int CLK_PERIOD = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_ns = 1'b0, cfg_err_resp = 1'b0, irq_clr = 1'b0, attr_sec = 1'b0;
   logic          up_req_valid = 1'b0, up_req_write = 1'b0;
   logic [AW-1:0] up_req_addr = '0;
   logic [DW-1:0] up_req_wdata = '0;
   logic          up_req_ready, up_rsp_valid, up_rsp_err;
   logic          up_rsp_ready = 1'b1;
   logic [DW-1:0] up_rsp_rdata;
   logic          dn_req_valid, dn_req_write, dn_req_ns;
   logic          dn_req_ready = 1'b1;
   logic [AW-1:0] dn_req_addr;
   logic [DW-1:0] dn_req_wdata;
   logic          dn_rsp_valid = 1'b0, dn_rsp_err = 1'b0;
   logic          dn_rsp_ready;
   logic [DW-1:0] dn_rsp_rdata = '0;
   logic          irq;

   int  n_vec = 0;
   int  n_miss = 0;
   bit  done = 0;
   logic exp_rej = 1'b0;
   logic irq_exp = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   msf_bus_filter #(.AW(AW), .DW(DW)) dut (.*);

   // reference model of the sticky interrupt (R6, R7)
   always @(posedge clk) begin
      if (!rst_n)       irq_exp <= 1'b0;
      else if (irq_clr) irq_exp <= 1'b0;
      else if (exp_rej) irq_exp <= 1'b1;
   end

   function automatic bit refused(input bit ns, input bit sec);
      return ns & sec;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (!ok) begin
         n_miss++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report;
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
         $finish;
      end
   endtask

   task automatic txn(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input bit ns, input bit sec, input bit errm, input bit clr, input int stall);
      bit blk;
      logic [DW-1:0] rd;
      bit re;
      blk = refused(ns, sec);
      @(negedge clk);
      cfg_ns = ns; attr_sec = sec; cfg_err_resp = errm; irq_clr = clr;
      up_req_write = wr; up_req_addr = a; up_req_wdata = d; up_req_valid = 1'b1;
      up_rsp_ready = 1'b1;
      if (!blk) begin
         for (int i = 0; i < stall; i++) begin
            dn_req_ready = 1'b0;
            #1;
            chk(up_req_ready == 1'b0, "R2 ready follows downstream", up_req_ready, 0);
            chk(dn_req_valid == 1'b1, "R2 request held downstream", dn_req_valid, 1);
            @(negedge clk);
         end
      end else begin
         dn_req_ready = ($urandom % 2 == 0);
      end
      exp_rej = blk;
      #1;
      if (blk) begin
         chk(dn_req_valid == 1'b0, "R3 refused not forwarded", dn_req_valid, 0);
         chk(up_req_ready == 1'b1, "R3 refused accepted at once", up_req_ready, 1);
      end else begin
         dn_req_ready = 1'b1;
         #1;
         chk(dn_req_valid == 1'b1, ns ? "R2 forwarded" : "R1 forwarded", dn_req_valid, 1);
         chk(dn_req_addr == a && dn_req_write == wr && dn_req_wdata == d,
             "R1 fields unchanged", {dn_req_addr, dn_req_wdata}, {a, d});
         chk(dn_req_ns == ns, ns ? "R2 ns attribute" : "R1 ns attribute", dn_req_ns, ns);
      end
      @(negedge clk);
      up_req_valid = 1'b0; exp_rej = 1'b0; dn_req_ready = 1'b1;
      if (!blk) begin
         rd = $urandom; re = $urandom % 2;
         dn_rsp_valid = 1'b1; dn_rsp_rdata = rd; dn_rsp_err = re;
         #1;
         chk(up_rsp_valid == 1'b1 && up_rsp_err == re && up_rsp_rdata == rd,
             "R8 response pass", {up_rsp_err, up_rsp_rdata}, {re, rd});
         chk(dn_rsp_ready == 1'b1, "R8 response ready", dn_rsp_ready, 1);
         @(negedge clk);
         dn_rsp_valid = 1'b0;
      end else begin
         #1;
         chk(up_rsp_valid == 1'b1 && up_rsp_rdata == '0, errm ? "R4 local rsp data" : "R5 local rsp data",
             up_rsp_rdata, 0);
         chk(up_rsp_err == errm, errm ? "R4 error response" : "R5 okay response", up_rsp_err, errm);
         chk(dn_req_valid == 1'b0, "R5 refused access absent downstream", dn_req_valid, 0);
         chk(irq == irq_exp, clr ? "R7 clear wins" : "R6 irq set", irq, irq_exp);
         @(negedge clk);
      end
      #1;
      chk(up_rsp_valid == 1'b0, "R9 response closed", up_rsp_valid, 0);
      chk(irq == irq_exp, "R6 irq sticky", irq, irq_exp);
      irq_clr = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_miss++;
      $display("FAIL watchdog expired actual=0 expected=1");
      report();
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      #1;
      chk(irq == 1'b0, "R10 irq after reset", irq, 0);
      chk(up_rsp_valid == 1'b0, "R10 rsp after reset", up_rsp_valid, 0);
      rst_n = 1'b1;

      // directed: secure master to secure space forwarded (R1)
      txn(1'b1, 32'h1000_0040, 32'hCAFE_0001, 1'b0, 1'b1, 1'b1, 1'b0, 1);
      // directed: refusals in both modes (R4, R5)
      txn(1'b0, 32'h2000_0000, 32'h0, 1'b1, 1'b1, 1'b1, 1'b0, 0);
      txn(1'b1, 32'h2000_0004, 32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, 1'b0, 0);
      // directed: clear pulse drops irq (R7)
      @(negedge clk); irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0; #1;
      chk(irq == 1'b0, "R7 clear pulse", irq, 0);
      // directed: clear on the same edge as a refusal (R7)
      txn(1'b0, 32'h2000_0008, 32'h0, 1'b1, 1'b1, 1'b0, 1'b1, 0);
      // directed: second request while first is open (R9)
      @(negedge clk);
      cfg_ns = 1'b1; attr_sec = 1'b0; up_req_write = 1'b0; up_req_addr = 32'h30; up_req_valid = 1'b1;
      @(negedge clk);
      up_req_addr = 32'h34;
      for (int i = 0; i < 3; i++) begin
         #1;
         chk(up_req_ready == 1'b0 && dn_req_valid == 1'b0, "R9 busy blocks new request",
             {up_req_ready, dn_req_valid}, 0);
         @(negedge clk);
      end
      up_req_valid = 1'b0;
      dn_rsp_valid = 1'b1; dn_rsp_rdata = 32'h5A5A; dn_rsp_err = 1'b0;
      @(negedge clk);
      dn_rsp_valid = 1'b0;
      #1;
      chk(up_rsp_valid == 1'b0, "R9 open transaction closed", up_rsp_valid, 0);

      // constrained random mix
      for (int k = 0; k < 300; k++) begin
         bit ns, sec;
         ns = $urandom % 2; sec = $urandom % 2;
         txn($urandom % 2, $urandom, $urandom, ns, sec, $urandom % 2,
             ($urandom % 8) == 0, refused(ns, sec) ? 0 : int'($urandom % 3));
      end
      report();
   end
endmodule